// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block decides what a display controller does with the words it fetches from memory at the start of each frame. A start-of-frame strobe, taken while the sequencer is idle and enabled, starts a load. A 2-bit load mode picks what is loaded: a colour palette followed by the pixel data, the palette alone, or the pixel data alone. Palette words go to a palette RAM write port. Pixel words go out on a registered valid/ready pixel stream.

The pixel depth is not held in a register that software writes. It comes from a 3-bit code inside the first palette word. That code also sets how many palette words the load takes: the long palette for the 1/2/4/8-bit depths and the short palette for the 12/16-bit depth. A palette-loaded status flag rises with the last palette write. Software can clear it only after a palette-only load. Dropping the enable clears the flag in every case and aborts any load in progress.

Top module: `lds_top`

## Requirements
- R1: With load_mode = 0, an accepted start-of-frame first loads a full palette and then passes exactly FRAME_WORDS words to the pixel stream, then returns to idle.
- R2: With load_mode = 1, only the palette is loaded. px_valid never rises, and in_ready is low once the last palette word has been taken.
- R3: With load_mode = 2, exactly FRAME_WORDS pixel words are passed. There is no palette write, and pal_loaded keeps its value.
- R4: load_mode = 3 is reserved. A start-of-frame with it is ignored and in_ready stays low.
- R5: Bits 14:12 of the first palette word give depth_code. Codes 0 to 3 (1, 2, 4 and 8 bpp) select PAL_BIG entries. Code 4 (12/16 bpp) selects PAL_SMALL entries. depth_code resets to 0.
- R6: Codes 5 to 7 leave depth_code unchanged, so the palette length follows the previous depth. They set depth_err, which stays set until the next accepted start-of-frame.
- R7: Each accepted palette word appears on pal_wdata with pal_we high one clock later. Addresses run 0, 1, 2 and so on up to the palette length minus one.
- R8: pal_loaded rises on the same clock edge as the last palette write.
- R9: A pal_clr pulse clears pal_loaded only when the most recently started load used load_mode = 1. Otherwise it has no effect.
- R10: With enable low, pal_loaded is cleared, the sequencer goes back to idle and start-of-frame is ignored.
- R11: A start-of-frame that arrives while a load is in progress is ignored. The load keeps its length.
- R12: While px_valid is high and px_ready is low, px_data holds its value and in_ready is low during the pixel phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low aborts and clears status |
| load_mode | input | 2 | 0 palette+frame, 1 palette only, 2 frame only, 3 reserved |
| sof | input | 1 | Start-of-frame strobe |
| pal_clr | input | 1 | Software clear request for pal_loaded |
| in_data | input | DW | Fetched word |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Sequencer takes in_data this cycle |
| pal_we | output | 1 | Palette RAM write enable |
| pal_addr | output | clog2(PAL_BIG) | Palette RAM write address |
| pal_wdata | output | DW | Palette RAM write data |
| px_data | output | DW | Pixel word |
| px_valid | output | 1 | px_data is valid |
| px_ready | input | 1 | Pixel consumer takes px_data |
| pal_loaded | output | 1 | Last palette entry has been written |
| depth_code | output | 3 | Current pixel depth code |
| depth_err | output | 1 | First palette word carried a code from 5 to 7 |

## Verification
Suppose the phase state or the word counter goes wrong. The total of palette writes and pixel words differs from the expected length, and the step from palette to pixels or to idle lands on the wrong word. The bench sees this within the same load, because it counts every write and every pixel against the table. A wrong depth register shows up one load later, as a palette of the wrong length after an invalid code. A wrong status flag shows up right after the last palette write, or at the first pal_clr or enable drop that follows.

// File: rtl/lds_pkg.sv
package lds_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PAL, ST_FRM} lds_state_e;
  localparam logic [1:0] MODE_BOTH = 2'd0;
  localparam logic [1:0] MODE_PAL  = 2'd1;
  localparam logic [1:0] MODE_FRM  = 2'd2;
  localparam int DEPTH_LSB = 12;
  localparam logic [2:0] DEPTH_MAX = 3'd4;
endpackage

// File: rtl/lds_depth.sv
module lds_depth
  import lds_pkg::*;
#(
  parameter int DW        = 16,
  parameter int PAL_BIG   = 256,
  parameter int PAL_SMALL = 32,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sof_take,
  input  logic          first_we,
  input  logic [DW-1:0] first_word,
  output logic [2:0]    depth_q,
  output logic          depth_err,
  output logic [CW-1:0] len_last
);
  logic [2:0] code_in;
  logic       code_ok;
  logic [2:0] eff_code;

  assign code_in  = first_word[DEPTH_LSB +: 3];
  assign code_ok  = (code_in <= DEPTH_MAX);
  assign eff_code = code_ok ? code_in : depth_q;
  assign len_last = (eff_code == DEPTH_MAX) ? CW'(PAL_SMALL - 1) : CW'(PAL_BIG - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q   <= 3'd0;
      depth_err <= 1'b0;
    end else begin
      if (sof_take) depth_err <= 1'b0;
      if (first_we) begin
        if (code_ok) depth_q   <= code_in;
        else         depth_err <= 1'b1;
      end
    end
  end

  // R6
  depth_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(first_we) |-> $stable(depth_q));

  // R5
  depth_range_chk: assert property (@(posedge clk) disable iff (rst)
    depth_q <= DEPTH_MAX);
endmodule

// File: rtl/lds_ctrl.sv
module lds_ctrl
  import lds_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 8,
  parameter int CW          = 8,
  parameter int FRAME_WORDS = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          sof,
  input  logic [1:0]    load_mode,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          px_ready,
  input  logic [CW-1:0] len_last,
  output logic          sof_take,
  output logic          first_we,
  output logic          pal_done,
  output logic [1:0]    mode_q,
  output logic          pal_we,
  output logic [AW-1:0] pal_addr,
  output logic [DW-1:0] pal_wdata,
  output logic          px_valid,
  output logic [DW-1:0] px_data
);
  localparam logic [CW-1:0] FRM_LAST = CW'(FRAME_WORDS - 1);

  lds_state_e    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] pal_last_q;
  logic [CW-1:0] last_idx;
  logic          take;

  always_comb begin
    in_ready = 1'b0;
    if (enable) begin
      case (state)
        ST_PAL:  in_ready = 1'b1;
        ST_FRM:  in_ready = !px_valid || px_ready;
        default: in_ready = 1'b0;
      endcase
    end
  end

  assign take     = in_valid && in_ready;
  assign sof_take = enable && (state == ST_IDLE) && sof && (load_mode != 2'd3);
  assign first_we = (state == ST_PAL) && take && (cnt == '0);
  assign last_idx = (cnt == '0) ? len_last : pal_last_q;
  assign pal_done = (state == ST_PAL) && take && (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pal_we   <= 1'b0;
      px_valid <= 1'b0;
      if (rst) begin
        mode_q     <= MODE_BOTH;
        pal_last_q <= '0;
        pal_addr   <= '0;
        pal_wdata  <= '0;
        px_data    <= '0;
      end
    end else begin
      pal_we <= 1'b0;
      if (px_valid && px_ready) px_valid <= 1'b0;
      case (state)
        ST_IDLE: if (sof_take) begin
          mode_q <= load_mode;
          cnt    <= '0;
          state  <= (load_mode == MODE_FRM) ? ST_FRM : ST_PAL;
        end
        ST_PAL: if (take) begin
          pal_we    <= 1'b1;
          pal_addr  <= cnt[AW-1:0];
          pal_wdata <= in_data;
          if (cnt == '0) pal_last_q <= len_last;
          if (pal_done) begin
            cnt   <= '0;
            state <= (mode_q == MODE_BOTH) ? ST_FRM : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FRM: if (take) begin
          px_valid <= 1'b1;
          px_data  <= in_data;
          if (cnt == FRM_LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  px_mode_chk: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> (mode_q != MODE_PAL));

  // R7
  pal_first_chk: assert property (@(posedge clk) disable iff (rst)
    first_we |=> (pal_we && pal_addr == '0));

  // R12
  px_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && px_valid && !px_ready) |=> (px_valid && $stable(px_data)));
endmodule

// File: rtl/lds_status.sv
module lds_status
  import lds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       pal_done,
  input  logic       clr_req,
  input  logic [1:0] mode_q,
  output logic       pal_loaded
);
  always_ff @(posedge clk) begin
    if (rst || !enable)                          pal_loaded <= 1'b0;
    else if (pal_done)                           pal_loaded <= 1'b1;
    else if (clr_req && mode_q == MODE_PAL)      pal_loaded <= 1'b0;
  end

  // R10
  dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pal_loaded);

  // R9
  clr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && pal_loaded && mode_q != MODE_PAL) |=> pal_loaded);
endmodule

// File: rtl/lds_top.sv
module lds_top
  import lds_pkg::*;
#(
  parameter int DW          = 16,
  parameter int PAL_BIG     = 256,
  parameter int PAL_SMALL   = 32,
  parameter int FRAME_WORDS = 1024,
  localparam int AW         = $clog2(PAL_BIG),
  localparam int CW         = $clog2((PAL_BIG > FRAME_WORDS) ? PAL_BIG : FRAME_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [1:0]    load_mode,
  input  logic          sof,
  input  logic          pal_clr,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          pal_we,
  output logic [AW-1:0] pal_addr,
  output logic [DW-1:0] pal_wdata,
  output logic [DW-1:0] px_data,
  output logic          px_valid,
  input  logic          px_ready,
  output logic          pal_loaded,
  output logic [2:0]    depth_code,
  output logic          depth_err
);
  logic          sof_take;
  logic          first_we;
  logic          pal_done;
  logic [1:0]    mode_q;
  logic [CW-1:0] len_last;

  lds_depth #(.DW(DW), .PAL_BIG(PAL_BIG), .PAL_SMALL(PAL_SMALL), .CW(CW)) u_depth (
    .clk(clk), .rst(rst), .sof_take(sof_take), .first_we(first_we),
    .first_word(in_data), .depth_q(depth_code), .depth_err(depth_err),
    .len_last(len_last)
  );

  lds_ctrl #(.DW(DW), .AW(AW), .CW(CW), .FRAME_WORDS(FRAME_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .sof(sof), .load_mode(load_mode),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .px_ready(px_ready), .len_last(len_last), .sof_take(sof_take),
    .first_we(first_we), .pal_done(pal_done), .mode_q(mode_q),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .px_valid(px_valid), .px_data(px_data)
  );

  lds_status u_status (
    .clk(clk), .rst(rst), .enable(enable), .pal_done(pal_done),
    .clr_req(pal_clr), .mode_q(mode_q), .pal_loaded(pal_loaded)
  );

  // R8
  loaded_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pal_loaded) |-> (pal_we && (pal_addr == AW'(PAL_BIG - 1) ||
                                      pal_addr == AW'(PAL_SMALL - 1))));
endmodule

// File: tb/sim_lds_top.sv
module sim_lds_top;
  localparam int DW = 16;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic [1:0] load_mode = 2'd0;
  logic sof = 1'b0, pal_clr = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic pal_we, px_valid, px_ready = 1'b1, pal_loaded, depth_err;
  logic [7:0] pal_addr;
  logic [DW-1:0] pal_wdata, px_data;
  logic [2:0] depth_code;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lds_top #(.DW(DW), .PAL_BIG(256), .PAL_SMALL(32), .FRAME_WORDS(FW)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .load_mode(load_mode), .sof(sof),
    .pal_clr(pal_clr), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .px_data(px_data), .px_valid(px_valid), .px_ready(px_ready),
    .pal_loaded(pal_loaded), .depth_code(depth_code), .depth_err(depth_err)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] first;
    logic [8:0]  npal;
    logic [7:0]  npx;
    logic [2:0]  depth;
    logic        err;
    logic        loaded;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{2'd0, 16'h4000, 9'd32,  8'd8, 3'd4, 1'b0, 1'b1},  // R1 R5 short palette
    '{2'd1, 16'h0000, 9'd256, 8'd0, 3'd0, 1'b0, 1'b1},  // R2 R5 long palette
    '{2'd2, 16'h4000, 9'd0,   8'd8, 3'd0, 1'b0, 1'b1},  // R3 frame only
    '{2'd0, 16'h3000, 9'd256, 8'd8, 3'd3, 1'b0, 1'b1},  // R1 code 3
    '{2'd1, 16'h6000, 9'd256, 8'd0, 3'd3, 1'b1, 1'b1},  // R6 invalid, keeps 3
    '{2'd1, 16'h4000, 9'd32,  8'd0, 3'd4, 1'b0, 1'b1},  // R5 code 4
    '{2'd1, 16'h7000, 9'd32,  8'd0, 3'd4, 1'b1, 1'b1},  // R6 invalid, keeps 4
    '{2'd3, 16'h0000, 9'd0,   8'd0, 3'd4, 1'b1, 1'b1}   // R4 reserved
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(int idx, int npal, logic [15:0] first);
    if (idx < npal) return (idx == 0) ? first : DW'(16'h0100 + idx);
    return DW'(16'hA000 + idx - npal);
  endfunction

  task automatic run_load(input vec_t v, input bit mid_sof);
    int wi = 0, pw = 0, pc = 0;
    int np = int'(v.npal), nx = int'(v.npx);
    @(negedge clk);
    load_mode = v.mode; sof = 1'b1;
    for (int c = 0; c < np + nx + 6; c++) begin
      @(negedge clk);
      sof = (mid_sof && c == 5);
      if (pal_we) begin
        chk(pal_addr == 8'(pw), "R7 addr", pal_addr, pw);
        chk(pal_wdata == word_of(pw, np, v.first), "R7 data", pal_wdata, word_of(pw, np, v.first));
        if (pw == np - 1) chk(pal_loaded == 1'b1, "R8 loaded with last write", pal_loaded, 1);
        pw++;
      end
      if (px_valid) begin
        chk(px_data == word_of(np + pc, np, v.first), "R1 pixel data", px_data, word_of(np + pc, np, v.first));
        pc++;
      end
      in_valid = 1'b1;
      in_data  = word_of(wi, np, v.first);
      if (in_ready) wi++;
    end
    in_valid = 1'b0;
    sof = 1'b0;
    chk(pw == np, "R1 R2 R3 R11 palette writes", pw, np);
    chk(pc == nx, "R1 R2 R3 pixel count", pc, nx);
    chk(wi == np + nx, "R4 R11 words taken", wi, np + nx);
    chk(depth_code == v.depth, "R5 R6 depth", depth_code, v.depth);
    chk(depth_err == v.err, "R6 depth_err", depth_err, v.err);
    chk(pal_loaded == v.loaded, "R3 R8 pal_loaded", pal_loaded, v.loaded);
    chk(in_ready == 1'b0, "R2 idle after load", in_ready, 0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 0 && pal_we == 0 && px_valid == 0, "R10 reset outputs", in_ready, 0);
    chk(pal_loaded == 0, "R8 reset pal_loaded", pal_loaded, 0);
    chk(depth_code == 0 && depth_err == 0, "R5 reset depth", depth_code, 0);

    for (int i = 0; i < 8; i++) run_load(TBL[i], 1'b0);

    // R11: sof in mid palette load does not restart it
    run_load('{2'd1, 16'h4000, 9'd32, 8'd0, 3'd4, 1'b0, 1'b1}, 1'b1);

    // R9: clear works after a palette-only load
    @(negedge clk); pal_clr = 1'b1;
    @(negedge clk); pal_clr = 1'b0;
    chk(pal_loaded == 0, "R9 clear after palette-only", pal_loaded, 0);

    // R9: clear ignored after combined load
    run_load('{2'd0, 16'h4000, 9'd32, 8'd8, 3'd4, 1'b0, 1'b1}, 1'b0);
    @(negedge clk); pal_clr = 1'b1;
    @(negedge clk); pal_clr = 1'b0;
    chk(pal_loaded == 1, "R9 clear ignored after combined load", pal_loaded, 1);

    // R10: disable clears status, sof ignored while disabled
    enable = 1'b0;
    @(negedge clk);
    chk(pal_loaded == 0, "R10 disable clears pal_loaded", pal_loaded, 0);
    load_mode = 2'd1; sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    @(negedge clk);
    chk(in_ready == 0, "R10 sof ignored when disabled", in_ready, 0);
    enable = 1'b1;

    // R10: disable mid-load aborts
    load_mode = 2'd1; sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    in_valid = 1'b1; in_data = 16'h0000;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk(in_ready == 0, "R10 abort to idle", in_ready, 0);
    chk(pal_loaded == 0, "R10 no status after abort", pal_loaded, 0);
    in_valid = 1'b0;

    // R12: pixel backpressure
    px_ready = 1'b0;
    load_mode = 2'd2; sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    in_valid = 1'b1; in_data = 16'hA5A5;
    @(negedge clk);
    in_data = 16'h5A5A;
    repeat (3) @(negedge clk);
    chk(px_valid == 1, "R12 valid held", px_valid, 1);
    chk(px_data == 16'hA5A5, "R12 data held", px_data, 16'hA5A5);
    chk(in_ready == 0, "R12 input stalled", in_ready, 0);
    px_ready = 1'b1;
    repeat (12) @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 0 && px_valid == 0, "R12 drained to idle", in_ready, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule